// File: doc/BRIEF.md
# Indexed Block-Transfer Register Target for a Two-Wire Bus

This block is a target on a two-wire serial bus (SMBus/I2C electrical style). It holds a small bank of 8-bit configuration registers, such as output-enable and mode bits for a clock fanout device. The register contents leave the block on a parallel bus. The host reaches the bank through indexed block transfers. Every transfer carries a byte count. On writes the host sends the count. On reads the target returns the count first, taken from a writable count register.

A write frame is: start, write address, start index, byte count, then that many data bytes, then stop. A read frame is: start, write address, start index, repeated start, read address. The target then returns the count byte, followed by register bytes beginning at the index, for as long as the host acknowledges. Three select inputs give the target one of eight bus addresses, so several devices can share one segment. The pads are open drain. The block therefore never drives SDA high: it only asserts a drive-low enable.

Top module: `smb_blk_target`

## Requirements
- R1: With the select inputs at 3'b000, the target acknowledges the address byte 0xDC (write) and 0xDD (read). Any other address byte receives no acknowledge, and the bytes that follow it are neither acknowledged nor acted on until the next start.
- R2: The 7-bit address is 7'h6E XOR {4'b0, sel}. The select value is captured on the first clock after reset, and later changes of the select inputs have no effect.
- R3: In a write frame, the target acknowledges the address, index N, count X and each of the X data bytes, and stores those bytes in registers N, N+1, ... in order.
- R4: A data byte beyond the X announced in a write frame receives no acknowledge and is not stored. The target then ignores the bus until the next start.
- R5: In a read frame, the first byte returned is the count register (index 8). The register bytes follow, starting at the index last set by a write frame, one per host acknowledge, MSB first.
- R6: After the host answers a returned byte with a NACK, the target releases SDA and drives nothing more until the next start.
- R7: The index pointer advances after each data byte and wraps from the last register (index 8) to index 0, on both reads and writes.
- R8: A write to an index at or above the register count (9) is acknowledged but discarded. A read at such an index returns 0x00.
- R9: A start or stop that arrives before all 8 bits of a byte are in discards that byte and leaves the registers unchanged. A start begins a new address phase.
- R10: After reset, registers 0 to 7 hold 0xFF (all outputs enabled) and the count register holds 0x08. Register i appears on bits [8i+7:8i] of the bank output.
- R11: The SDA drive-low enable changes only while SCL is low, following a falling SCL edge. SDA is sampled on rising SCL edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the bus lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 3 | Address select, captured after reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_drive_low_o | output | 1 | When high, the pad pulls SDA low |
| reg_bank_o | output | NREG*8 | Register bank, register i at bits [8i+7:8i] |

## Verification
The hardest cases to reach are framing faults that land inside a byte: a stop after a few data bits, a repeated start after a partial byte, and a data byte that overruns the announced count. The bench bit-bangs the bus. It has a task that clocks only the top bits of a byte and then issues a start or a stop. After each such fault it checks the whole bank on the parallel output, and then runs a clean transfer to show that the target has recovered. A separate monitor records every change of the drive enable that happens while the host holds SCL high.

// File: rtl/smbt_pkg.sv
package smbt_pkg;
   localparam int IDX_W = 8;
   typedef enum logic [1:0] {M_IDLE, M_RX, M_TX} mode_t;
   typedef enum logic [1:0] {PH_ADDR, PH_INDEX, PH_COUNT, PH_DATA} phase_t;
endpackage

// File: rtl/smbt_line_sync.sv
module smbt_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_evt,
   output logic stop_evt
);
   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_d  <= scl_sh[STAGES-1];
         sda_d  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smbt_regbank.sv
module smbt_regbank import smbt_pkg::*; #(
   parameter int         NREG    = 9,
   parameter int         CNT_IDX = 8,
   parameter logic [7:0] OUT_RST = 8'hFF,
   parameter logic [7:0] CNT_RST = 8'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  idx,
   input  logic [7:0]        wdata,
   output logic [7:0]        rdata,
   output logic [7:0]        cnt_val,
   output logic [NREG*8-1:0] bank_o
);
   logic [7:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      localparam logic [7:0] RST_V = (i == CNT_IDX) ? CNT_RST : OUT_RST;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs[i] <= RST_V;
         else if (we && idx == IDX_W'(i))
            regs[i] <= wdata;
      end
      assign bank_o[8*i +: 8] = regs[i];
   end

   always_comb begin
      rdata = 8'h00;
      for (int i = 0; i < NREG; i++)
         if (idx == IDX_W'(i)) rdata = regs[i];
   end

   assign cnt_val = regs[CNT_IDX];
endmodule

// File: rtl/smbt_engine.sv
module smbt_engine import smbt_pkg::*; #(
   parameter int         NREG      = 9,
   parameter logic [6:0] ADDR_BASE = 7'h6E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       sel_i,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_evt,
   input  logic             stop_evt,
   input  logic             sda_s,
   input  logic [7:0]       rd_data,
   input  logic [7:0]       cnt_val,
   output logic             drv_o,
   output logic             wr_en_o,
   output logic [IDX_W-1:0] ptr_o,
   output logic [7:0]       wr_data_o,
   output logic             busy_o,
   output logic [3:0]       cnt_o,
   output logic [2:0]       sel_q_o,
   output logic             sel_cap_o
);
   localparam logic [IDX_W:0]   NREG_W = (IDX_W+1)'(NREG);
   localparam logic [IDX_W-1:0] LAST   = IDX_W'(NREG - 1);

   mode_t            mode;
   phase_t           phase;
   logic [3:0]       cnt;
   logic [7:0]       shreg, txb, remain;
   logic [IDX_W-1:0] ptr, nxt_ptr;
   logic             drv, go_tx, host_nack;
   logic [2:0]       sel_q;
   logic             sel_cap;
   logic [6:0]       my_addr;
   logic             rx_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= 3'b000;
         sel_cap <= 1'b0;
      end else if (!sel_cap) begin
         sel_q   <= sel_i;
         sel_cap <= 1'b1;
      end
   end

   assign my_addr = ADDR_BASE ^ {4'b0000, sel_q};
   assign nxt_ptr = (ptr == LAST) ? '0 : ptr + 1'b1;
   assign rx_done = scl_fall && mode == M_RX && cnt == 4'd8;
   assign wr_en_o = rx_done && phase == PH_DATA && remain != 8'h00 &&
                    {1'b0, ptr} < NREG_W;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode      <= M_IDLE;
         phase     <= PH_ADDR;
         cnt       <= '0;
         shreg     <= '0;
         txb       <= '0;
         remain    <= '0;
         ptr       <= '0;
         drv       <= 1'b0;
         go_tx     <= 1'b0;
         host_nack <= 1'b0;
      end else if (start_evt) begin
         mode  <= M_RX;
         phase <= PH_ADDR;
         cnt   <= '0;
         drv   <= 1'b0;
         go_tx <= 1'b0;
      end else if (stop_evt) begin
         mode  <= M_IDLE;
         cnt   <= '0;
         drv   <= 1'b0;
         go_tx <= 1'b0;
      end else if (mode != M_IDLE) begin
         if (scl_rise) begin
            if (cnt < 4'd8) begin
               if (mode == M_RX) shreg <= {shreg[6:0], sda_s};
               cnt <= cnt + 4'd1;
            end else if (cnt == 4'd8) begin
               host_nack <= sda_s;
               cnt       <= 4'd9;
            end
         end else if (scl_fall) begin
            if (cnt == 4'd8) begin
               if (mode == M_TX) begin
                  drv <= 1'b0;
               end else begin
                  case (phase)
                     PH_ADDR: begin
                        if (shreg[7:1] == my_addr) begin
                           drv <= 1'b1;
                           if (shreg[0]) go_tx <= 1'b1;
                           else          phase <= PH_INDEX;
                        end else begin
                           mode <= M_IDLE;
                           drv  <= 1'b0;
                        end
                     end
                     PH_INDEX: begin
                        ptr   <= shreg;
                        drv   <= 1'b1;
                        phase <= PH_COUNT;
                     end
                     PH_COUNT: begin
                        remain <= shreg;
                        drv    <= 1'b1;
                        phase  <= PH_DATA;
                     end
                     default: begin
                        if (remain != 8'h00) begin
                           drv    <= 1'b1;
                           remain <= remain - 8'h01;
                           ptr    <= nxt_ptr;
                        end else begin
                           mode <= M_IDLE;
                           drv  <= 1'b0;
                        end
                     end
                  endcase
               end
            end else if (cnt == 4'd9) begin
               cnt <= '0;
               if (mode == M_TX) begin
                  if (host_nack) begin
                     mode <= M_IDLE;
                     drv  <= 1'b0;
                  end else begin
                     txb <= rd_data;
                     drv <= ~rd_data[7];
                     ptr <= nxt_ptr;
                  end
               end else if (go_tx) begin
                  mode  <= M_TX;
                  txb   <= cnt_val;
                  drv   <= ~cnt_val[7];
                  go_tx <= 1'b0;
               end else begin
                  drv <= 1'b0;
               end
            end else if (mode == M_TX && cnt != 4'd0) begin
               drv <= ~txb[3'd7 - cnt[2:0]];
            end
         end
      end
   end

   assign drv_o     = drv;
   assign ptr_o     = ptr;
   assign wr_data_o = shreg;
   assign busy_o    = mode != M_IDLE;
   assign cnt_o     = cnt;
   assign sel_q_o   = sel_q;
   assign sel_cap_o = sel_cap;
endmodule

// File: rtl/smb_blk_target.sv
module smb_blk_target import smbt_pkg::*; #(
   parameter int         NREG        = 9,
   parameter int         CNT_IDX     = 8,
   parameter logic [6:0] ADDR_BASE   = 7'h6E,
   parameter logic [7:0] OUT_RST     = 8'hFF,
   parameter logic [7:0] CNT_RST     = 8'h08,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        sel_i,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_drive_low_o,
   output logic [NREG*8-1:0] reg_bank_o
);
   if (NREG < 2 || NREG > (1 << IDX_W)) begin : g_bad_nreg
      $error("NREG must lie between 2 and the index range");
   end
   if (CNT_IDX < 0 || CNT_IDX >= NREG) begin : g_bad_cnt
      $error("CNT_IDX must name an implemented register");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
   logic             wr_en, busy, sel_cap;
   logic [IDX_W-1:0] ptr;
   logic [7:0]       wr_data, rd_data, cnt_val;
   logic [3:0]       bit_cnt;
   logic [2:0]       sel_q;

   smbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt)
   );

   smbt_engine #(.NREG(NREG), .ADDR_BASE(ADDR_BASE)) u_eng (
      .clk(clk), .rst_n(rst_n), .sel_i(sel_i),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
      .rd_data(rd_data), .cnt_val(cnt_val),
      .drv_o(sda_drive_low_o), .wr_en_o(wr_en), .ptr_o(ptr),
      .wr_data_o(wr_data), .busy_o(busy), .cnt_o(bit_cnt),
      .sel_q_o(sel_q), .sel_cap_o(sel_cap)
   );

   smbt_regbank #(.NREG(NREG), .CNT_IDX(CNT_IDX),
                  .OUT_RST(OUT_RST), .CNT_RST(CNT_RST)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(wr_en), .idx(ptr), .wdata(wr_data),
      .rdata(rd_data), .cnt_val(cnt_val), .bank_o(reg_bank_o)
   );
endmodule

// File: rtl/smbt_chk.sv
module smbt_chk #(
   parameter int BANK_W = 72
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_s,
   input logic              stop_evt,
   input logic              drv,
   input logic              busy,
   input logic [3:0]        cnt,
   input logic              sel_cap,
   input logic [2:0]        sel_q,
   input logic              wr_en,
   input logic [BANK_W-1:0] bank
);
   AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(drv) |-> !scl_s);                                        // R11
   AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_evt |=> !drv);                                               // R9
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !drv);                                                  // R6
   AST_BIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= 4'd9);                                                     // R3
   AST_BANK_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(bank) |-> $past(wr_en));                                 // R9
   AST_WRITE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> busy);                                                  // R3
   AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sel_cap) |-> $stable(sel_q));                               // R2
endmodule

bind smb_blk_target smbt_chk #(.BANK_W(NREG*8)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
   .drv(sda_drive_low_o), .busy(busy), .cnt(bit_cnt), .sel_cap(sel_cap),
   .sel_q(sel_q), .wr_en(wr_en), .bank(reg_bank_o)
);

// File: tb/sim_smb_blk_target.sv
module sim_smb_blk_target;
   localparam int NREG = 9;
   localparam int Q    = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        sel = 3'b000;
   logic              scl_h = 1'b1, sda_h = 1'b1;
   logic              drv;
   logic              sda_line;
   logic [NREG*8-1:0] bank;

   int n_chk = 0, n_fail = 0, viol = 0;
   bit done = 1'b0;
   logic       drv_prev = 1'b0;
   logic [7:0] exp_r  [NREG];
   logic [7:0] tx_buf [8];
   logic [7:0] rx_buf [8];

   always #2.5 clk = ~clk;
   assign sda_line = sda_h & ~drv;

   smb_blk_target u0 (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .scl_i(scl_h), .sda_i(sda_line),
      .sda_drive_low_o(drv), .reg_bank_o(bank)
   );

   // R11 monitor: the drive enable must not move while the host holds SCL high
   always @(negedge clk) begin
      if (rst_n && drv !== drv_prev && scl_h) viol++;
      drv_prev = drv;
   end

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic chk_bank(input string tag);
      logic [NREG*8-1:0] e;
      for (int i = 0; i < NREG; i++) e[8*i +: 8] = exp_r[i];
      chk(tag, 128'(bank), 128'(e));
   endtask

   task automatic wq();
      repeat (Q) @(posedge clk);
      #1;
   endtask

   task automatic bus_start();
      sda_h = 1'b1; wq(); scl_h = 1'b1; wq(); sda_h = 1'b0; wq(); scl_h = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_h = 1'b0; wq(); scl_h = 1'b1; wq(); sda_h = 1'b1; wq();
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_h = b[i]; wq(); scl_h = 1'b1; wq(); scl_h = 1'b0; wq();
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      send_bits(b, 8);
      sda_h = 1'b1; wq(); scl_h = 1'b1; wq();
      ack = ~sda_line;
      scl_h = 1'b0; wq();
   endtask

   task automatic recv_byte(input logic host_ack, output logic [7:0] b);
      sda_h = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         wq(); scl_h = 1'b1; wq(); b[i] = sda_line; scl_h = 1'b0;
      end
      wq(); sda_h = ~host_ack; wq(); scl_h = 1'b1; wq(); scl_h = 1'b0; wq();
      sda_h = 1'b1;
   endtask

   // returns ack per byte: bit0 address, bit1 index, bit2 count, bit3+ data
   task automatic blk_write(input logic [7:0] a, input logic [7:0] n, input logic [7:0] x,
                            input int nb, output logic [15:0] acks);
      logic k;
      acks = '0;
      bus_start();
      send_byte(a, k); acks[0] = k;
      send_byte(n, k); acks[1] = k;
      send_byte(x, k); acks[2] = k;
      for (int i = 0; i < nb; i++) begin
         send_byte(tx_buf[i], k); acks[3+i] = k;
      end
      bus_stop();
   endtask

   // rx_buf[0] = count byte, then nb data bytes (last NACKed), then one extra clocked byte
   task automatic blk_read(input logic [7:0] n, input int nb, output logic [2:0] acks);
      logic k;
      logic [7:0] b;
      bus_start();
      send_byte(8'hDC, k); acks[0] = k;
      send_byte(n, k);     acks[1] = k;
      bus_start();
      send_byte(8'hDD, k); acks[2] = k;
      recv_byte(1'b1, b); rx_buf[0] = b;
      for (int i = 1; i <= nb; i++) begin
         recv_byte(i != nb, b); rx_buf[i] = b;
      end
      recv_byte(1'b0, b); rx_buf[nb+1] = b;
      chk("R6 drive released after NACK", 128'(drv), 128'(0));
      bus_stop();
   endtask

   task automatic do_reset(input logic [2:0] s);
      rst_n = 1'b0; sel = s; scl_h = 1'b1; sda_h = 1'b1;
      repeat (5) @(posedge clk);
      #1 rst_n = 1'b1;
      repeat (5) @(posedge clk);
      #1;
      for (int i = 0; i < NREG; i++) exp_r[i] = (i == 8) ? 8'h08 : 8'hFF;
   endtask

   task automatic t_reset();
      chk_bank("R10 reset values");
      chk("R10 drive idle after reset", 128'(drv), 128'(0));
   endtask

   task automatic t_write_basic();
      logic [15:0] a;
      tx_buf[0] = 8'hA1; tx_buf[1] = 8'hB2; tx_buf[2] = 8'hC3;
      blk_write(8'hDC, 8'd2, 8'd3, 3, a);
      exp_r[2] = 8'hA1; exp_r[3] = 8'hB2; exp_r[4] = 8'hC3;
      chk("R1 R3 acks for block write", 128'(a), 128'(16'h003F));
      chk_bank("R3 registers 2..4 written");
   endtask

   task automatic t_overrun();
      logic [15:0] a;
      tx_buf[0] = 8'h11; tx_buf[1] = 8'h22;
      blk_write(8'hDC, 8'd0, 8'd1, 2, a);
      exp_r[0] = 8'h11;
      chk("R4 byte beyond count NACKed", 128'(a), 128'(16'h000F));
      chk_bank("R4 extra byte not stored");
   endtask

   task automatic t_read_basic();
      logic [2:0] a;
      blk_read(8'd2, 3, a);
      chk("R5 read frame acks", 128'(a), 128'(3'b111));
      chk("R5 count byte first", 128'(rx_buf[0]), 128'(8'h08));
      chk("R5 data from index", 128'({rx_buf[1], rx_buf[2], rx_buf[3]}), 128'(24'hA1B2C3));
      chk("R6 nothing sent after NACK", 128'(rx_buf[4]), 128'(8'hFF));
   endtask

   task automatic t_wrap();
      logic [15:0] a;
      logic [2:0]  r;
      tx_buf[0] = 8'h03;
      blk_write(8'hDC, 8'd8, 8'd1, 1, a);
      exp_r[8] = 8'h03;
      chk_bank("R5 count register writable");
      blk_read(8'd7, 3, r);
      chk("R5 returned count follows register", 128'(rx_buf[0]), 128'(8'h03));
      chk("R7 read wraps 8 to 0", 128'({rx_buf[1], rx_buf[2], rx_buf[3]}), 128'(24'hFF0311));
      tx_buf[0] = 8'h05; tx_buf[1] = 8'h5A;
      blk_write(8'hDC, 8'd8, 8'd2, 2, a);
      exp_r[8] = 8'h05; exp_r[0] = 8'h5A;
      chk("R7 write wrap acks", 128'(a), 128'(16'h001F));
      chk_bank("R7 write wraps 8 to 0");
   endtask

   task automatic t_out_of_range();
      logic [15:0] a;
      logic [2:0]  r;
      tx_buf[0] = 8'h77; tx_buf[1] = 8'h88;
      blk_write(8'hDC, 8'h14, 8'd2, 2, a);
      chk("R8 out-of-range write acked", 128'(a), 128'(16'h001F));
      chk_bank("R8 out-of-range write discarded");
      blk_read(8'h14, 2, r);
      chk("R8 out-of-range read zero", 128'({rx_buf[0], rx_buf[1], rx_buf[2]}), 128'(24'h050000));
   endtask

   task automatic t_bad_addr();
      logic [15:0] a;
      tx_buf[0] = 8'h99;
      blk_write(8'hDE, 8'd1, 8'd1, 1, a);
      chk("R1 foreign address not acked", 128'(a), 128'(16'h0000));
      blk_write(8'h90, 8'd1, 8'd1, 1, a);
      chk("R1 unrelated address not acked", 128'(a), 128'(16'h0000));
      chk_bank("R1 foreign frames ignored");
   endtask

   task automatic t_abort();
      logic k;
      logic [15:0] a;
      bus_start();
      send_byte(8'hDC, k); send_byte(8'd1, k); send_byte(8'd1, k);
      send_bits(8'h00, 4);
      bus_stop();
      chk_bank("R9 stop mid-byte discards");
      bus_start();
      send_byte(8'hDC, k); send_byte(8'd1, k); send_byte(8'd1, k);
      send_bits(8'h00, 3);
      bus_start();
      a = '0;
      send_byte(8'hDC, k); a[0] = k;
      send_byte(8'd1, k);  a[1] = k;
      send_byte(8'd1, k);  a[2] = k;
      send_byte(8'h42, k); a[3] = k;
      bus_stop();
      exp_r[1] = 8'h42;
      chk("R9 start mid-byte restarts address phase", 128'(a), 128'(16'h000F));
      chk_bank("R9 only the clean frame stored");
   endtask

   task automatic t_select();
      logic [15:0] a;
      sel = 3'b111;
      wq();
      tx_buf[0] = 8'h66;
      blk_write(8'hDC, 8'd5, 8'd1, 1, a);
      exp_r[5] = 8'h66;
      chk("R2 select change after reset ignored", 128'(a), 128'(16'h000F));
      chk_bank("R2 write with original address");
      do_reset(3'b011);
      chk_bank("R10 reset values again");
      blk_write(8'hDC, 8'd6, 8'd1, 1, a);
      chk("R2 old address rejected", 128'(a), 128'(16'h0000));
      tx_buf[0] = 8'h3C;
      blk_write(8'hDA, 8'd6, 8'd1, 1, a);
      exp_r[6] = 8'h3C;
      chk("R2 selected address 0xDA acked", 128'(a), 128'(16'h000F));
      chk_bank("R2 write through selected address");
   endtask

   initial begin
      do_reset(3'b000);
      t_reset();
      t_write_basic();
      t_overrun();
      t_read_basic();
      t_wrap();
      t_out_of_range();
      t_bad_addr();
      t_abort();
      t_select();
      chk("R11 drive changes only with SCL low", 128'(viol), 128'(0));
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule